// File: doc/BRIEF.md
# PWM Timebase with Double-Buffered Period

This block is the timebase of a pulse-width modulator. A free-running prescaler divides the input clock into a slower tick. An up-counter advances on each tick from zero to a period limit and then wraps. Each time the count is zero on a tick, the block raises a one-cycle zero event. Compare and duty logic elsewhere in the chip uses this event and the count.

Software writes one configuration word through a single-cycle write strobe. The word holds the prescale divisor, a new period and a two-bit policy. The period goes into a shadow register. The limit the counter actually uses is a separate active register. The policy decides when the shadow is copied into it:

- at once,
- at the next zero event,
- at the next external sync pulse, or
- at whichever of those two events comes first.

This lets the period change without a glitch in the middle of a cycle.

Top module: `pwm_tb_top`

## Requirements
- R1: While reset is held and right after it, the prescale is 0, the shadow and active periods are both 255, the policy is 0 and the count is 0.
- R2: A tick occurs once every prescale+1 clocks, so a prescale of 0 ticks on every clock. Any configuration write restarts the prescaler: the first tick after a write falls prescale+1 clocks after the write edge, counting that edge as clock one.
- R3: On each tick the count goes up by one. When the count equals or exceeds the active period it returns to 0 instead. An active period of 0 holds the count at 0.
- R4: `zeroEvt` is high for exactly the clock cycles in which a tick occurs while the count is 0.
- R5: The configuration word carries the prescale in bits 7:0, the period in bits 23:8 and the policy in bits 25:24.
- R6: With policy 0, the active period takes the written period at the clock edge of the write itself.
- R7: With policy 1, the shadow is copied at the first zero event after the write. Sync pulses have no effect on the active period.
- R8: With policy 2, the shadow is copied at the first sync pulse after the write. Zero events have no effect on the active period.
- R9: With policy 3, the shadow is copied at the first zero event or sync pulse after the write, whichever comes first.
- R10: A pending copy survives later writes. The copy always moves the most recently written period, under the most recently written policy. A zero event or sync pulse in the same cycle as a write does not trigger a copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Single-cycle configuration write strobe |
| cfgWord | input | 26 | Configuration word: prescale, period, policy |
| syncIn | input | 1 | External sync event, one cycle per event |
| count | output | 16 | Current timebase count |
| zeroEvt | output | 1 | Count-is-zero tick pulse |
| activePeriod | output | 16 | Period limit currently used by the counter |

## Verification
The assertions assume three things about the inputs:
- `syncIn` and `cfgWrEn` are single-cycle pulses that are sampled on the rising edge.
- Nothing but a write or one of the two events changes the active period.
- The policy field in a write is always meaningful.

The stimulus drives every input on the falling edge and holds each pulse for exactly one clock. It also deliberately lines a write up with a sync pulse, so that the rule that a write wins over an event is exercised and not merely assumed. The periods and prescales are chosen small enough that every policy sees several zero events within a short run, and also large enough to shrink the period below a running count.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

  // Strobes from the control half to the datapath half, valid for one clock.
  typedef struct packed {
    logic tick;        // prescaled timebase tick
    logic wrCfg;       // configuration write in this cycle
    logic loadImm;     // active period takes the freshly written period
    logic loadShadow;  // active period takes the shadow period
  } tbStrobe_t;

  // Policy that governs the shadow-to-active copy.
  typedef enum logic [1:0] {
    UPD_NOW    = 2'd0,
    UPD_ZERO   = 2'd1,
    UPD_SYNC   = 2'd2,
    UPD_EITHER = 2'd3
  } updMode_t;

  // True when the stored policy accepts one of the two events.
  function automatic logic modeAccepts(updMode_t m, logic zeroHit, logic syncHit);
    logic onZero;
    logic onSync;
    onZero = (m == UPD_ZERO) || (m == UPD_EITHER);
    onSync = (m == UPD_SYNC) || (m == UPD_EITHER);
    return (onZero && zeroHit) || (onSync && syncHit);
  endfunction

endpackage

// File: rtl/pwm_tb_ctrl.sv
module pwm_tb_ctrl
  import pwm_tb_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [PRE_W-1:0] wrPrescale,
  input  logic [1:0]       wrMode,
  input  logic             syncIn,
  input  logic             zeroEvt,
  output tbStrobe_t        strb
);

  logic [PRE_W-1:0] prescaleReg;
  logic [PRE_W-1:0] preCnt;
  updMode_t         modeReg;
  logic             pending;
  logic             tick;
  logic             copyNow;
  updMode_t         wrModeE;

  assign wrModeE = updMode_t'(wrMode);
  assign tick    = (preCnt == prescaleReg);
  assign copyNow = !cfgWrEn && pending && modeAccepts(modeReg, zeroEvt, syncIn);

  // Prescaler: counts 0..prescale, restarts on any configuration write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (cfgWrEn || tick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + {{(PRE_W-1){1'b0}}, 1'b1};
    end
  end

  // Stored prescale and policy.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescaleReg <= '0;
      modeReg     <= UPD_NOW;
    end else if (cfgWrEn) begin
      prescaleReg <= wrPrescale;
      modeReg     <= wrModeE;
    end
  end

  // Pending-copy flag.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (cfgWrEn) begin
      pending <= (wrModeE != UPD_NOW);
    end else if (copyNow) begin
      pending <= 1'b0;
    end
  end

  always_comb begin
    strb            = '0;
    strb.tick       = tick;
    strb.wrCfg      = cfgWrEn;
    strb.loadImm    = cfgWrEn && (wrModeE == UPD_NOW);
    strb.loadShadow = copyNow;
  end

  // R2: the prescaler never runs past the stored divisor.
  p_precnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= prescaleReg);

  // R10: a write cycle never performs a shadow copy.
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |-> !strb.loadShadow);

  // R10: nothing is left pending once a policy-0 write has taken effect.
  p_imm_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && wrModeE == UPD_NOW) |=> !pending);

endmodule

// File: rtl/pwm_tb_dpath.sv
module pwm_tb_dpath
  import pwm_tb_pkg::*;
#(
  parameter int PER_W      = 16,
  parameter int RST_PERIOD = 255
) (
  input  logic             clk,
  input  logic             rstN,
  input  tbStrobe_t        strb,
  input  logic [PER_W-1:0] wrPeriod,
  output logic [PER_W-1:0] count,
  output logic [PER_W-1:0] activePeriod,
  output logic             zeroEvt
);

  localparam logic [PER_W-1:0] RST_VAL = PER_W'(RST_PERIOD);
  localparam logic [PER_W-1:0] ONE     = PER_W'(1);

  logic [PER_W-1:0] shadowPeriod;
  logic             atLimit;

  assign atLimit = (count >= activePeriod);
  assign zeroEvt = strb.tick && (count == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowPeriod <= RST_VAL;
    end else if (strb.wrCfg) begin
      shadowPeriod <= wrPeriod;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activePeriod <= RST_VAL;
    end else if (strb.loadImm) begin
      activePeriod <= wrPeriod;
    end else if (strb.loadShadow) begin
      activePeriod <= shadowPeriod;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strb.tick) begin
      count <= atLimit ? '0 : count + ONE;
    end
  end

  // R3: the count only moves on a tick.
  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.tick |=> $stable(count));

  // R3: reaching or passing the limit on a tick returns to zero.
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && count >= activePeriod) |=> count == '0);

  // R7: without a load strobe the active period holds.
  p_active_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadImm && !strb.loadShadow) |=> $stable(activePeriod));

endmodule

// File: rtl/pwm_tb_top.sv
module pwm_tb_top
  import pwm_tb_pkg::*;
#(
  parameter int PRE_W      = 8,
  parameter int PER_W      = 16,
  parameter int RST_PERIOD = 255,
  localparam int PER_LSB   = PRE_W,
  localparam int MODE_LSB  = PRE_W + PER_W,
  localparam int CFG_W     = MODE_LSB + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             syncIn,
  output logic [PER_W-1:0] count,
  output logic             zeroEvt,
  output logic [PER_W-1:0] activePeriod
);

  tbStrobe_t        strb;
  logic [PRE_W-1:0] wrPrescale;
  logic [PER_W-1:0] wrPeriod;
  logic [1:0]       wrMode;

  // R5: field placement inside the configuration word.
  assign wrPrescale = cfgWord[PER_LSB-1:0];
  assign wrPeriod   = cfgWord[MODE_LSB-1:PER_LSB];
  assign wrMode     = cfgWord[CFG_W-1:MODE_LSB];

  pwm_tb_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .wrPrescale (wrPrescale),
    .wrMode     (wrMode),
    .syncIn     (syncIn),
    .zeroEvt    (zeroEvt),
    .strb       (strb)
  );

  pwm_tb_dpath #(.PER_W(PER_W), .RST_PERIOD(RST_PERIOD)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .wrPeriod     (wrPeriod),
    .count        (count),
    .activePeriod (activePeriod),
    .zeroEvt      (zeroEvt)
  );

  // R6: a policy-0 write shows up on the next edge.
  p_imm_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && wrMode == 2'd0) |=> activePeriod == $past(wrPeriod));

  // R9: with no write and no event, the active period cannot change.
  p_no_event_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWrEn && !zeroEvt && !syncIn) |=> $stable(activePeriod));

endmodule

// File: tb/sim_pwm_tb_top.sv
module sim_pwm_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [25:0] cfgWord = '0;
  logic        syncIn = 1'b0;
  logic [15:0] count;
  logic        zeroEvt;
  logic [15:0] activePeriod;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit running = 1'b0;
  string curReq = "R1";

  // Behavioural reference state.
  int mPre = 0, mDiv = 0, mCnt = 0, mAct = 255, mShadow = 255, mMode = 0;
  bit mPend = 0;

  always #10 clk = ~clk;

  pwm_tb_top u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWord(cfgWord),
    .syncIn(syncIn), .count(count), .zeroEvt(zeroEvt), .activePeriod(activePeriod)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // Reference model advances on each rising edge.
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mPre = 0; mDiv = 0; mCnt = 0; mAct = 255; mShadow = 255; mMode = 0; mPend = 0;
    end else begin
      bit t, z;
      t = (mDiv == mPre);
      z = t && (mCnt == 0);
      if (t) mCnt = (mCnt >= mAct) ? 0 : mCnt + 1;
      if (cfgWrEn || t) mDiv = 0; else mDiv = mDiv + 1;
      if (cfgWrEn) begin
        mPre    = int'(cfgWord[7:0]);
        mShadow = int'(cfgWord[23:8]);
        mMode   = int'(cfgWord[25:24]);
        if (mMode == 0) begin mAct = mShadow; mPend = 0; end
        else mPend = 1;
      end else if (mPend && ((mMode[0] && z) || (mMode[1] && syncIn))) begin
        mAct = mShadow; mPend = 0;
      end
    end
  end

  // Compare away from the active edge.
  always @(negedge clk) begin
    if (running) begin
      bit expZero;
      expZero = (mDiv == mPre) && (mCnt == 0);
      check(int'(count) == mCnt, curReq, "count", int'(count), mCnt);
      check(zeroEvt == expZero, curReq, "zeroEvt", int'(zeroEvt), int'(expZero));
      check(int'(activePeriod) == mAct, curReq, "activePeriod", int'(activePeriod), mAct);
    end
    if (cycles > 150000) begin
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      finishRun();
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeCfg(input int pre, input int per, input int mode, input bit withSync);
    @(negedge clk);
    cfgWord = {mode[1:0], per[15:0], pre[7:0]};
    cfgWrEn = 1'b1;
    syncIn  = withSync;
    @(negedge clk);
    cfgWrEn = 1'b0;
    syncIn  = 1'b0;
  endtask

  task automatic pulseSync();
    @(negedge clk);
    syncIn = 1'b1;
    @(negedge clk);
    syncIn = 1'b0;
  endtask

  initial begin
    // R1: reset values observed at the ports.
    idle(3);
    check(count == 16'd0, "R1", "reset count", int'(count), 0);
    check(activePeriod == 16'd255, "R1", "reset activePeriod", int'(activePeriod), 255);
    check(zeroEvt == 1'b1, "R1", "reset zeroEvt", int'(zeroEvt), 1);
    rstN = 1'b1;
    running = 1'b1;

    curReq = "R3"; idle(600);                     // default period 255 wraps twice
    curReq = "R5"; writeCfg(3, 10, 0, 0); idle(120);
    curReq = "R2"; writeCfg(0, 7, 0, 0); idle(40);
    writeCfg(255, 2, 0, 0); idle(1100);
    writeCfg(5, 4, 0, 0); idle(9); writeCfg(5, 4, 0, 0); idle(60);
    curReq = "R3"; writeCfg(0, 200, 0, 0); idle(150);
    writeCfg(0, 20, 0, 0); idle(50);              // shrink below running count
    writeCfg(0, 0, 0, 0); idle(20);               // zero period
    curReq = "R4"; writeCfg(2, 3, 0, 0); idle(60);
    curReq = "R6"; writeCfg(0, 33, 0, 0); idle(5);
    writeCfg(1, 15, 0, 0); idle(80);
    curReq = "R7"; writeCfg(1, 30, 1, 0);
    pulseSync(); idle(3); pulseSync(); idle(120);
    curReq = "R8"; writeCfg(0, 12, 2, 0); idle(200);
    pulseSync(); idle(60);
    curReq = "R9"; writeCfg(0, 40, 3, 0); idle(80);
    writeCfg(0, 8, 3, 0); idle(2); pulseSync(); idle(40);
    curReq = "R10"; writeCfg(0, 50, 2, 0); idle(30);
    writeCfg(0, 60, 2, 0); idle(20); pulseSync(); idle(70);
    writeCfg(0, 70, 2, 0); writeCfg(0, 25, 1, 0); idle(10); pulseSync(); idle(120);
    writeCfg(0, 18, 2, 1); idle(30);               // sync with write: no copy
    pulseSync(); idle(40);
    writeCfg(0, 9, 1, 0); idle(300);

    running = 1'b0;
    finishRun();
  end

endmodule